// File: doc/BRIEF.md
# Aliased Interrupt Mask Bank

This block keeps one mask bit for every maskable interrupt source of a microcontroller and makes that bit reachable from two places: a bank of halfword mask registers on the peripheral bus, and the mask field of the matching per-source control register. Both views share the same storage flop, so whichever path writes the bit, the other path reads the new value on the next cycle. A mask bit of 1 blocks the source and a 0 lets it through. The bank drives a flat mask vector to the interrupt controller and also forwards each pending flag that is not masked, registered once.

Bus requests carry an operation code. A halfword-aligned address selects a bank register, a byte-enable pair selects the low half, the high half or both, and a bit number selects a single position for set, clear or test. Offsets outside the bank, and odd offsets, read as all ones and change nothing. Positions that no source owns are tied to 1.

Top module: `imr_bank`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, every mask bit is 1, `irq_o` is all zeros and `bus_rvalid` is 0.
- R2: Bank register k sits at byte offset 0x100 + 2·k (k = 0, 1, 2). A read (op code 0) returns the full 16-bit register on `bus_rdata` with `bus_rvalid` high on the cycle after the request. A write (op code 1) with byte enables 11 replaces all 16 bits.
- R3: A write with byte enables 01 changes bits 7:0 only. With 10 it changes bits 15:8 only. With 00 it changes nothing.
- R4: Bit set (op code 2) and bit clear (op code 3) force the bit named by `bus_bit` to 1 or 0 within one clock cycle and leave every other bit as it was.
- R5: Bit test (op code 4) returns the selected bit in `bus_rdata` bit 0, with all other `bus_rdata` bits 0, and changes no state.
- R6: Bits 15:6 of bank register 2 read as 1 and ignore every write, whether it comes from the bus or from the control-register port.
- R7: A control-register write (`ctl_wr`) with source number s = 16·k + b, where k is the bank register and b the bit, loads `ctl_mask` into that bit. `ctl_rmask` shows the current mask of source `ctl_src` combinationally, so bus writes are visible on it. Source numbers 48 and above are ignored and read as 1.
- R8: When a bus write and a control-register write hit the same bit in the same cycle, the control-register value is stored.
- R9: `irq_o` equals the previous cycle's `pend_i` ANDed with the inverse of the previous cycle's mask.
- R10: A request to an offset outside 0x100..0x105, or to an odd offset, returns 0xFFFF for a read or a test and leaves all mask bits unchanged.
- R11: `mask_o` bit 16·k + b is bit b of bank register k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus request strobe, one cycle per request |
| bus_op | input | 3 | Operation: 0 read, 1 write, 2 bit set, 3 bit clear, 4 bit test |
| bus_addr | input | 12 | Byte offset in the peripheral space |
| bus_be | input | 2 | Byte enables for writes: bit 0 low half, bit 1 high half |
| bus_bit | input | 4 | Bit number for set, clear and test |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read or test result, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read result strobe, the cycle after a read or test |
| ctl_wr | input | 1 | Write strobe for the mask field of a per-source control register |
| ctl_src | input | 6 | Source number for control-register access |
| ctl_mask | input | 1 | Mask value written by `ctl_wr` |
| ctl_rmask | output | 1 | Mask of source `ctl_src` as seen by the control register |
| pend_i | input | 48 | Pending flags, one per source |
| mask_o | output | 48 | Mask vector to the interrupt controller |
| irq_o | output | 48 | Registered unmasked requests |

## Verification
Two things can land in the same cycle: a bus write to a bank register and a control-register write of a mask field. A collision is forced by driving a full halfword write of zeros and a control-register write of 1 to one bit of that register in the same cycle, and then a bus clear together with a control-register set on the same bit. In both cases the read-back must show the control value in the colliding bit and the bus value in every other bit. The bench also uses control-register writes to touch the tied-high positions and source numbers beyond the bank, and reads the bank and `mask_o` afterwards to show that these writes had no effect.

// File: rtl/imr_pkg.sv
package imr_pkg;

   // Bus operation codes; the numeric values are part of the bus contract.
   typedef enum logic [2:0] {
      OP_RD  = 3'd0,
      OP_WR  = 3'd1,
      OP_SET = 3'd2,
      OP_CLR = 3'd3,
      OP_TST = 3'd4
   } imr_op_e;

   function automatic logic op_writes(input imr_op_e op);
      return (op == OP_WR) || (op == OP_SET) || (op == OP_CLR);
   endfunction

   function automatic logic op_reads(input imr_op_e op);
      return (op == OP_RD) || (op == OP_TST);
   endfunction

endpackage

// File: rtl/imr_addr_dec.sv
module imr_addr_dec #(
   parameter int ADDR_W   = 12,
   parameter int BASE     = 'h100,
   parameter int NUM_REGS = 3,
   parameter int IDX_W    = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);

   logic [ADDR_W-1:0] off;

   assign off = addr - ADDR_W'(BASE);
   // Halfword registers: even offsets inside the window only.
   assign hit = (addr >= ADDR_W'(BASE)) && (off < ADDR_W'(2 * NUM_REGS)) && !addr[0];
   assign idx = off[IDX_W:1];

endmodule

// File: rtl/imr_reg_slice.sv
module imr_reg_slice
   import imr_pkg::*;
#(
   parameter int               REG_W = 16,
   parameter logic [REG_W-1:0] FIXED = '0,
   localparam int              BIT_W = $clog2(REG_W),
   localparam int              BE_W  = REG_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  imr_op_e          op,
   input  logic [BE_W-1:0]  be,
   input  logic [BIT_W-1:0] bit_sel,
   input  logic [REG_W-1:0] wdata,
   input  logic             ctl_we,
   input  logic [BIT_W-1:0] ctl_bit,
   input  logic             ctl_val,
   output logic [REG_W-1:0] q
);

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (FIXED[b]) begin : g_tie
         // No source owns this position: constant 1, no storage.
         logic unused_in;
         assign unused_in = ^{wdata[b], be[b/8], bit_sel, ctl_bit, ctl_val,
                              ctl_we, bus_we, op, clk, rst_n};
         assign q[b] = 1'b1;
      end else begin : g_ff
         logic lane_hit, pos_hit, own_ctl, nxt, bit_q;

         assign lane_hit = (op == OP_WR) && be[b/8];
         assign pos_hit  = ((op == OP_SET) || (op == OP_CLR)) && (bit_sel == BIT_W'(b));
         assign own_ctl  = ctl_we && (ctl_bit == BIT_W'(b));

         always_comb begin
            nxt = bit_q;
            if (bus_we && (lane_hit || pos_hit))
               nxt = (op == OP_WR) ? wdata[b] : (op == OP_SET);
            // Control-register path has the last word on its own bit.
            if (own_ctl)
               nxt = ctl_val;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b1;
            else        bit_q <= nxt;
         end

         assign q[b] = bit_q;
      end
   end

endmodule

// File: rtl/imr_irq_gate.sv
module imr_irq_gate #(
   parameter int NUM_SRC = 48
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] mask,
   output logic [NUM_SRC-1:0] irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= '0;
      else        irq <= pend & ~mask;
   end

endmodule

// File: rtl/imr_bank.sv
module imr_bank
   import imr_pkg::*;
#(
   parameter int                        ADDR_W     = 12,
   parameter int                        BASE_OFS   = 'h100,
   parameter int                        NUM_REGS   = 3,
   parameter int                        REG_W      = 16,
   parameter logic [NUM_REGS*REG_W-1:0] FIXED_ONES = 48'hFFC0_0000_0000,
   localparam int                       NUM_SRC    = NUM_REGS * REG_W,
   localparam int                       BIT_W      = $clog2(REG_W),
   localparam int                       BE_W       = REG_W / 8,
   localparam int                       IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int                       SRC_W      = IDX_W + BIT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   input  logic [2:0]         bus_op,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BE_W-1:0]    bus_be,
   input  logic [BIT_W-1:0]   bus_bit,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   output logic               bus_rvalid,
   input  logic               ctl_wr,
   input  logic [SRC_W-1:0]   ctl_src,
   input  logic               ctl_mask,
   output logic               ctl_rmask,
   input  logic [NUM_SRC-1:0] pend_i,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] irq_o
);

   // Elaboration-time parameter checks
   if (REG_W < 8 || (REG_W % 8) != 0) begin : g_bad_width
      $error("imr_bank: REG_W must be a multiple of 8");
   end
   if ((BASE_OFS % 2) != 0) begin : g_bad_base
      $error("imr_bank: BASE_OFS must be halfword aligned");
   end
   if (BASE_OFS + 2 * NUM_REGS > (1 << ADDR_W)) begin : g_bad_span
      $error("imr_bank: register window exceeds address space");
   end

   imr_op_e             op;
   logic                sel_hit;
   logic [IDX_W-1:0]    sel_idx;
   logic [REG_W-1:0]    reg_q [NUM_REGS];
   logic [IDX_W-1:0]    ctl_reg;
   logic [BIT_W-1:0]    ctl_bit;

   assign op      = imr_op_e'(bus_op);
   assign ctl_reg = ctl_src[SRC_W-1:BIT_W];
   assign ctl_bit = ctl_src[BIT_W-1:0];

   imr_addr_dec #(
      .ADDR_W   (ADDR_W),
      .BASE     (BASE_OFS),
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
   ) i_dec (
      .addr (bus_addr),
      .hit  (sel_hit),
      .idx  (sel_idx)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic bus_we_r, ctl_we_r;

      assign bus_we_r = bus_valid && sel_hit && (sel_idx == IDX_W'(r)) && op_writes(op);
      assign ctl_we_r = ctl_wr && (ctl_reg == IDX_W'(r));

      imr_reg_slice #(
         .REG_W (REG_W),
         .FIXED (FIXED_ONES[r*REG_W +: REG_W])
      ) i_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .bus_we  (bus_we_r),
         .op      (op),
         .be      (bus_be),
         .bit_sel (bus_bit),
         .wdata   (bus_wdata),
         .ctl_we  (ctl_we_r),
         .ctl_bit (ctl_bit),
         .ctl_val (ctl_mask),
         .q       (reg_q[r])
      );

      assign mask_o[r*REG_W +: REG_W] = reg_q[r];
   end

   // Control-register view of the shared bit; beyond the bank reads as masked.
   assign ctl_rmask = (int'(ctl_src) < NUM_SRC) ? mask_o[ctl_src] : 1'b1;

   // Registered read path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_valid && op_reads(op);
         if (bus_valid && op_reads(op)) begin
            if (!sel_hit)
               bus_rdata <= '1;
            else if (op == OP_RD)
               bus_rdata <= reg_q[sel_idx];
            else
               bus_rdata <= {{(REG_W-1){1'b0}}, reg_q[sel_idx][bus_bit]};
         end
      end
   end

   imr_irq_gate #(
      .NUM_SRC (NUM_SRC)
   ) i_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend_i),
      .mask  (mask_o),
      .irq   (irq_o)
   );

endmodule

// File: rtl/imr_bank_chk.sv
module imr_bank_chk #(
   parameter int                        NUM_REGS   = 3,
   parameter int                        REG_W      = 16,
   parameter logic [NUM_REGS*REG_W-1:0] FIXED_ONES = 48'hFFC0_0000_0000,
   localparam int                       NUM_SRC    = NUM_REGS * REG_W,
   localparam int                       BIT_W      = $clog2(REG_W),
   localparam int                       IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int                       SRC_W      = IDX_W + BIT_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_valid,
   input logic [2:0]         bus_op,
   input logic [BIT_W-1:0]   bus_bit,
   input logic               bus_rvalid,
   input logic               ctl_wr,
   input logic [SRC_W-1:0]   ctl_src,
   input logic               ctl_mask,
   input logic [NUM_SRC-1:0] pend_i,
   input logic [NUM_SRC-1:0] mask_o,
   input logic [NUM_SRC-1:0] irq_o,
   input logic               sel_hit,
   input logic [IDX_W-1:0]   sel_idx
);

   // R6
   fixed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o & FIXED_ONES) == FIXED_ONES);

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_o == ($past(pend_i) & ~$past(mask_o)));

   // R8
   ctl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && (int'(ctl_src) < NUM_SRC) && !FIXED_ONES[ctl_src])
      |=> mask_o[$past(ctl_src)] == $past(ctl_mask));

   // R10
   unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !sel_hit && !ctl_wr) |=> $stable(mask_o));

   // R5
   test_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_op == 3'd4 && !ctl_wr) |=> $stable(mask_o));

   // R4
   bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && sel_hit && bus_op == 3'd2 && !ctl_wr)
      |=> mask_o[int'($past(sel_idx)) * REG_W + int'($past(bus_bit))]);

   // R2
   rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && (bus_op == 3'd0 || bus_op == 3'd4)) |=> bus_rvalid);

   // R2
   rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && (bus_op == 3'd0 || bus_op == 3'd4)) |=> !bus_rvalid);

endmodule

bind imr_bank imr_bank_chk #(
   .NUM_REGS   (NUM_REGS),
   .REG_W      (REG_W),
   .FIXED_ONES (FIXED_ONES)
) i_imr_bank_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_op     (bus_op),
   .bus_bit    (bus_bit),
   .bus_rvalid (bus_rvalid),
   .ctl_wr     (ctl_wr),
   .ctl_src    (ctl_src),
   .ctl_mask   (ctl_mask),
   .pend_i     (pend_i),
   .mask_o     (mask_o),
   .irq_o      (irq_o),
   .sel_hit    (sel_hit),
   .sel_idx    (sel_idx)
);

// File: tb/test_imr_bank.sv
`timescale 1ns/1ps
module test_imr_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic [2:0]  bus_op = '0;
   logic [11:0] bus_addr = '0;
   logic [1:0]  bus_be = '0;
   logic [3:0]  bus_bit = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_rvalid;
   logic        ctl_wr = 1'b0;
   logic [5:0]  ctl_src = '0;
   logic        ctl_mask = 1'b0;
   logic        ctl_rmask;
   logic [47:0] pend_i = '0;
   logic [47:0] mask_o;
   logic [47:0] irq_o;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   imr_bank i_imr_bank (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_op(bus_op),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_bit(bus_bit),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .ctl_wr(ctl_wr), .ctl_src(ctl_src), .ctl_mask(ctl_mask),
      .ctl_rmask(ctl_rmask), .pend_i(pend_i), .mask_o(mask_o), .irq_o(irq_o)
   );

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic acc(input logic [2:0] op, input logic [11:0] a, input logic [1:0] be,
                      input logic [3:0] b, input logic [15:0] wd,
                      input logic chk, input logic [15:0] exp, input string tag);
      bus_valid = 1'b1; bus_op = op; bus_addr = a; bus_be = be; bus_bit = b; bus_wdata = wd;
      @(negedge clk);
      bus_valid = 1'b0;
      if (chk) begin
         check({48'd0, bus_rdata}, {48'd0, exp}, tag);
         check({63'd0, bus_rvalid}, 64'd1, {tag, " rvalid"});
      end
   endtask

   // {req(4), op(3), addr(12), be(2), bit(4), wdata(16), chk(1), exp(16)}
   localparam int NV = 27;
   localparam logic [57:0] VEC [NV] = '{
      {4'd2,  3'd0, 12'h100, 2'b11, 4'd0, 16'h0000, 1'b1, 16'hFFFF}, // R2 reset value
      {4'd2,  3'd1, 12'h100, 2'b11, 4'd0, 16'h1234, 1'b0, 16'h0000}, // R2
      {4'd2,  3'd0, 12'h100, 2'b11, 4'd0, 16'h0000, 1'b1, 16'h1234}, // R2
      {4'd3,  3'd1, 12'h102, 2'b01, 4'd0, 16'hABCD, 1'b0, 16'h0000}, // R3 low byte
      {4'd3,  3'd0, 12'h102, 2'b11, 4'd0, 16'h0000, 1'b1, 16'hFFCD}, // R3
      {4'd3,  3'd1, 12'h102, 2'b10, 4'd0, 16'h5A00, 1'b0, 16'h0000}, // R3 high byte
      {4'd3,  3'd0, 12'h102, 2'b11, 4'd0, 16'h0000, 1'b1, 16'h5ACD}, // R3
      {4'd3,  3'd1, 12'h102, 2'b00, 4'd0, 16'h0000, 1'b0, 16'h0000}, // R3 no lanes
      {4'd3,  3'd0, 12'h102, 2'b11, 4'd0, 16'h0000, 1'b1, 16'h5ACD}, // R3
      {4'd6,  3'd1, 12'h104, 2'b11, 4'd0, 16'h0000, 1'b0, 16'h0000}, // R6
      {4'd6,  3'd0, 12'h104, 2'b11, 4'd0, 16'h0000, 1'b1, 16'hFFC0}, // R6
      {4'd4,  3'd2, 12'h104, 2'b00, 4'd2, 16'h0000, 1'b0, 16'h0000}, // R4 set
      {4'd4,  3'd0, 12'h104, 2'b11, 4'd0, 16'h0000, 1'b1, 16'hFFC4}, // R4
      {4'd6,  3'd3, 12'h104, 2'b00, 4'd9, 16'h0000, 1'b0, 16'h0000}, // R6 clear tied bit
      {4'd6,  3'd3, 12'h104, 2'b00, 4'd7, 16'h0000, 1'b0, 16'h0000}, // R6
      {4'd6,  3'd0, 12'h104, 2'b11, 4'd0, 16'h0000, 1'b1, 16'hFFC4}, // R6
      {4'd4,  3'd3, 12'h100, 2'b00, 4'd4, 16'h0000, 1'b0, 16'h0000}, // R4 clear
      {4'd4,  3'd0, 12'h100, 2'b11, 4'd0, 16'h0000, 1'b1, 16'h1224}, // R4
      {4'd5,  3'd4, 12'h100, 2'b00, 4'd2, 16'h0000, 1'b1, 16'h0001}, // R5 test 1
      {4'd5,  3'd4, 12'h100, 2'b00, 4'd0, 16'h0000, 1'b1, 16'h0000}, // R5 test 0
      {4'd10, 3'd0, 12'h106, 2'b11, 4'd0, 16'h0000, 1'b1, 16'hFFFF}, // R10 past window
      {4'd10, 3'd1, 12'h106, 2'b11, 4'd0, 16'h0000, 1'b0, 16'h0000}, // R10
      {4'd10, 3'd1, 12'h101, 2'b11, 4'd0, 16'h0000, 1'b0, 16'h0000}, // R10 odd
      {4'd10, 3'd0, 12'h101, 2'b11, 4'd0, 16'h0000, 1'b1, 16'hFFFF}, // R10
      {4'd10, 3'd4, 12'h0FE, 2'b00, 4'd0, 16'h0000, 1'b1, 16'hFFFF}, // R10 below window
      {4'd10, 3'd0, 12'h100, 2'b11, 4'd0, 16'h0000, 1'b1, 16'h1224}, // R10 untouched
      {4'd10, 3'd0, 12'h102, 2'b11, 4'd0, 16'h0000, 1'b1, 16'h5ACD}  // R10 untouched
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired before the run finished (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      check({16'd0, mask_o}, {16'd0, 48'hFFFF_FFFF_FFFF}, "R1 mask in reset");
      check({16'd0, irq_o}, 64'd0, "R1 irq in reset");
      check({63'd0, bus_rvalid}, 64'd0, "R1 rvalid in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check({16'd0, mask_o}, {16'd0, 48'hFFFF_FFFF_FFFF}, "R1 mask after release");

      for (int i = 0; i < NV; i++) begin
         automatic logic [57:0] v = VEC[i];
         acc(v[53:51], v[50:39], v[38:37], v[36:33], v[32:17], v[16], v[15:0],
             $sformatf("R%0d table entry %0d", v[57:54], i));
      end

      // R7 control-register write reaches the bank
      ctl_wr = 1'b1; ctl_src = 6'd35; ctl_mask = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
      acc(3'd0, 12'h104, 2'b11, 4'd0, 16'h0, 1'b1, 16'hFFCC, "R7 ctl set reg2 bit3");
      // R7 bank contents visible through the control view
      ctl_src = 6'd4; #1;
      check({63'd0, ctl_rmask}, 64'd0, "R7 ctl view of src 4");
      ctl_src = 6'd2; #1;
      check({63'd0, ctl_rmask}, 64'd1, "R7 ctl view of src 2");
      ctl_src = 6'd50; #1;
      check({63'd0, ctl_rmask}, 64'd1, "R7 ctl view beyond bank");
      @(negedge clk);

      // R6 control write to a tied position, R7 write beyond the bank
      ctl_wr = 1'b1; ctl_src = 6'd40; ctl_mask = 1'b0;
      @(negedge clk);
      ctl_src = 6'd50;
      @(negedge clk);
      ctl_wr = 1'b0;
      check({16'd0, mask_o}, {16'd0, 48'hFFCC_5ACD_1224}, "R6 R7 ignored ctl writes");

      // R8 same-cycle collision, halfword write vs control set
      ctl_wr = 1'b1; ctl_src = 6'd1; ctl_mask = 1'b1;
      acc(3'd1, 12'h100, 2'b11, 4'd0, 16'h0000, 1'b0, 16'h0, "R8");
      ctl_wr = 1'b0;
      acc(3'd0, 12'h100, 2'b11, 4'd0, 16'h0, 1'b1, 16'h0002, "R8 halfword vs ctl");
      // R8 bus clear vs control set on the same bit
      ctl_wr = 1'b1; ctl_src = 6'd16; ctl_mask = 1'b1;
      acc(3'd3, 12'h102, 2'b00, 4'd0, 16'h0000, 1'b0, 16'h0, "R8");
      ctl_wr = 1'b0;
      acc(3'd0, 12'h102, 2'b11, 4'd0, 16'h0, 1'b1, 16'h5ACD, "R8 clear vs ctl");

      // R11 layout of the mask vector
      check({16'd0, mask_o}, {16'd0, 48'hFFCC_5ACD_0002}, "R11 mask vector layout");

      // R9 gating, registered
      pend_i = 48'hFFFF_FFFF_FFFF;
      @(negedge clk);
      check({16'd0, irq_o}, {16'd0, ~48'hFFCC_5ACD_0002}, "R9 all pending");
      pend_i = 48'h0000_0003_0001;
      @(negedge clk);
      check({16'd0, irq_o}, {16'd0, 48'h0000_0002_0001}, "R9 sparse pending");
      pend_i = '0;
      @(negedge clk);
      check({16'd0, irq_o}, 64'd0, "R9 nothing pending");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule